// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Port Controller

This block is the command and data-bus control front end of a flow-through synchronous SRAM. The SRAM has no turnaround cycle between reads and writes. On each enabled rising clock edge it samples three chip selects, a write command, per-lane write strobes and a load/advance control, and it registers the access they describe. A read returns data from the array in the cycle that follows its address. A write takes its data one enabled edge after the command, so reads and writes can alternate back to back.

A small behavioural array is built in so that the read path, the lane-masked write path and read-after-write can be observed at the ports. Each lane holds eight data bits and one parity bit. The parity bit sits at the top of the lane and is written under that lane's strobe. The bus drive enable is a registered internal enable gated by an asynchronous drive input, and it is suppressed whenever the bus must carry write data or the part is not selected. A freeze input stretches the current cycle: no state advances and no array write happens while it is high.

Top module: `fts_port_ctrl`

## Requirements
- R1: An access is started only at an enabled edge with `adv_nload`=0 and the select pattern `csa_n`=0, `csb`=1, `csc_n`=0. A load with any other pattern leaves the block deselected for the next cycle, with `bus_drive`=0 and `arr_wstb`=0 in that cycle.
- R2: A read loaded at edge k (`wr_n`=1) puts the array word at its address on `rdata` during the cycle after edge k, with `bus_drive`=1 when `drv_n`=0.
- R3: A write loaded at edge k (`wr_n`=0) stores `wdata` as sampled at the next enabled edge, k+1, into the addressed word.
- R4: Lane i covers bits [9i+8:9i] of `wdata` and `rdata`, with the parity bit at 9i+8. The lane is written only if `lane_wr_n[i]` was 0 when the write was loaded or advanced, and lanes whose strobe was high keep their old contents.
- R5: During the data cycle of a write, `arr_wstb[i]`=1 for each enabled lane while `freeze`=0. At every other time `arr_wstb` is all zero.
- R6: `bus_drive` equals the registered read enable ANDed with the inverse of `drv_n`. It follows `drv_n` at once, with no clock edge.
- R7: `bus_drive` is 0 during the write data cycle and while deselected, whatever the level of `drv_n`.
- R8: With `freeze`=1 at an edge, the access type, the address, `rdata`, `bus_drive` and the array contents are all held.
- R9: With `adv_nload`=1 at an enabled edge, the current access type is kept, the selects are ignored and the address steps by one, wrapping at the top of the range. Advancing while deselected stays deselected.
- R10: A read loaded at the edge that captures a write's data, and aimed at the same address, returns the new data in the very next cycle.
- R11: After an edge with `rst_n`=0 the block is deselected, with `bus_drive`=0 and `arr_wstb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| csa_n | input | 1 | Chip select A, active low |
| csb | input | 1 | Chip select B, active high |
| csc_n | input | 1 | Chip select C, active low |
| wr_n | input | 1 | Write command, active low, sampled on load |
| lane_wr_n | input | NL | Per-lane write strobes, active low |
| adv_nload | input | 1 | 1: advance the current access, 0: load a new one |
| freeze | input | 1 | 1: clock masked, all state held |
| drv_n | input | 1 | Asynchronous bus drive request, active low |
| addr | input | AW | Word address, sampled on load |
| wdata | input | NL*LW | Write data, sampled one enabled edge after the write command |
| rdata | output | NL*LW | Read data of the registered address |
| bus_drive | output | 1 | Data bus output enable |
| arr_wstb | output | NL | Array write strobes per lane |

## Verification
A write data cycle and a new command fall in the same cycle: the array is written from `wdata` at the very edge that loads the next access. The bench provokes this in three ways. It issues a read to the just-written address there (R10), it issues a masked write followed by a read of the merged word, and it holds a write's data cycle with `freeze` so that only the later edge may commit. Each case is judged by comparing `rdata`, `bus_drive` and `arr_wstb` in the following cycle against a lane merge computed in the bench.

// File: rtl/fts_pkg.sv
// Package: shared types of the flow-through SRAM port controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fts_pkg;

    // Access held in the pipeline register for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/fts_cmd_decode.sv
// Module: fts_cmd_decode
// Decodes the sampled command pins into the next access type, address and
// lane mask. A load with a valid select pattern starts a read or a write.
// An advance keeps the current access and steps the address, and a load
// without select deselects.
// Assumes: the caller only registers the outputs on enabled edges.
module fts_cmd_decode
    import fts_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic          csa_n,
    input  logic          csb,
    input  logic          csc_n,
    input  logic          wr_n,
    input  logic [NL-1:0] lane_wr_n,
    input  logic          adv_nload,
    input  logic [AW-1:0] addr,
    input  op_e           cur_op,
    input  logic [AW-1:0] cur_addr,
    output op_e           nxt_op,
    output logic [AW-1:0] nxt_addr,
    output logic [NL-1:0] nxt_lanes
);

    localparam logic [AW-1:0] STEP = AW'(1);

    logic selected;

    // Select pattern: A low, B high, C low.
    always_comb begin
        selected = !csa_n && csb && !csc_n;
    end

    // Next access type and address from load/advance.
    always_comb begin
        if (adv_nload) begin
            nxt_op   = cur_op;
            nxt_addr = cur_addr + STEP;
        end else if (selected) begin
            nxt_op   = wr_n ? OP_READ : OP_WRITE;
            nxt_addr = addr;
        end else begin
            nxt_op   = OP_IDLE;
            nxt_addr = cur_addr;
        end
    end

    // Lane mask is meaningful only for a write access.
    always_comb begin
        nxt_lanes = (nxt_op == OP_WRITE) ? ~lane_wr_n : '0;
    end

endmodule

// File: rtl/fts_pipe.sv
// Module: fts_pipe
// Pipeline register holding the access, address and lane mask of the
// current cycle. It loads only on an enabled edge.
// Assumes: synchronous active-low reset; reset leaves the block deselected.
module fts_pipe
    import fts_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  op_e           nxt_op,
    input  logic [AW-1:0] nxt_addr,
    input  logic [NL-1:0] nxt_lanes,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic [NL-1:0] lanes_q
);

    // Register the next access unless the clock is masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            lanes_q <= '0;
        end else if (!freeze) begin
            op_q    <= nxt_op;
            addr_q  <= nxt_addr;
            lanes_q <= nxt_lanes;
        end
    end

endmodule

// File: rtl/fts_array.sv
// Module: fts_array
// Behavioural storage with one write port per lane and an asynchronous
// read port. Each lane is LW bits wide, parity bit included.
// Assumes: contents are not reset; only written words are read back.
module fts_array #(
    parameter int AW = 4,
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic [NL-1:0] wstb,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Lane write under its own strobe.
        always_ff @(posedge clk) begin
            if (wstb[g]) begin
                mem[waddr] <= wdata[g*LW +: LW];
            end
        end

        // Flow-through lane read.
        always_comb begin
            rdata[g*LW +: LW] = mem[raddr];
        end
    end

endmodule

// File: rtl/fts_port_ctrl.sv
// Module: fts_port_ctrl (top)
// Control front end of a flow-through synchronous SRAM. Reads return data
// in the cycle after their address. Write data is taken one enabled edge
// after the command. The bus drive enable is held off in write data
// cycles and while deselected.
// Assumes: drv_n may change at any time; all other inputs are synchronous.
module fts_port_ctrl
    import fts_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csa_n,
    input  logic          csb,
    input  logic          csc_n,
    input  logic          wr_n,
    input  logic [NL-1:0] lane_wr_n,
    input  logic          adv_nload,
    input  logic          freeze,
    input  logic          drv_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bus_drive,
    output logic [NL-1:0] arr_wstb
);

    op_e           nxt_op;
    logic [AW-1:0] nxt_addr;
    logic [NL-1:0] nxt_lanes;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [NL-1:0] lanes_q;
    logic          rd_en_q;

    fts_cmd_decode #(.AW(AW), .NL(NL)) u_dec (
        .csa_n     (csa_n),
        .csb       (csb),
        .csc_n     (csc_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .adv_nload (adv_nload),
        .addr      (addr),
        .cur_op    (op_q),
        .cur_addr  (addr_q),
        .nxt_op    (nxt_op),
        .nxt_addr  (nxt_addr),
        .nxt_lanes (nxt_lanes)
    );

    fts_pipe #(.AW(AW), .NL(NL)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (freeze),
        .nxt_op    (nxt_op),
        .nxt_addr  (nxt_addr),
        .nxt_lanes (nxt_lanes),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .lanes_q   (lanes_q)
    );

    // Strobes fire in the write data cycle only on an enabled edge.
    always_comb begin
        arr_wstb = (op_q == OP_WRITE && !freeze) ? lanes_q : '0;
    end

    fts_array #(.AW(AW), .NL(NL), .LW(LW)) u_arr (
        .clk   (clk),
        .wstb  (arr_wstb),
        .waddr (addr_q),
        .wdata (wdata),
        .raddr (addr_q),
        .rdata (rdata)
    );

    // Internal drive enable: a read occupies the current cycle.
    always_comb begin
        rd_en_q = (op_q == OP_READ);
    end

    // Bus drive: internal enable gated by the asynchronous request.
    always_comb begin
        bus_drive = rd_en_q && !drv_n;
    end

endmodule

// File: rtl/fts_port_ctrl_chk.sv
// Module: fts_port_ctrl_chk
// Assertion checker bound into fts_port_ctrl. It watches the pins and the
// pipeline register.
// Assumes: bound with the same parameters as the top.
module fts_port_ctrl_chk
    import fts_pkg::*;
#(
    parameter int AW = 4,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csa_n,
    input  logic          csb,
    input  logic          csc_n,
    input  logic          adv_nload,
    input  logic          freeze,
    input  logic          drv_n,
    input  logic          bus_drive,
    input  logic [NL-1:0] arr_wstb,
    input  op_e           op_q,
    input  logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] ONE = AW'(1);

    p_wr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wstb != '0) |-> !bus_drive);

    p_drv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_n |-> !bus_drive);

    p_freeze_nostb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (arr_wstb == '0));

    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(op_q) && $stable(addr_q)));

    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !adv_nload && !(!csa_n && csb && !csc_n))
        |=> (!bus_drive && arr_wstb == '0));

    p_adv_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && adv_nload && op_q != OP_IDLE)
        |=> (addr_q == $past(addr_q) + ONE));

    p_adv_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && adv_nload && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (op_q == OP_IDLE && arr_wstb == '0));

endmodule

bind fts_port_ctrl fts_port_ctrl_chk #(.AW(AW), .NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csa_n     (csa_n),
    .csb       (csb),
    .csc_n     (csc_n),
    .adv_nload (adv_nload),
    .freeze    (freeze),
    .drv_n     (drv_n),
    .bus_drive (bus_drive),
    .arr_wstb  (arr_wstb),
    .op_q      (op_q),
    .addr_q    (addr_q)
);

// File: tb/fts_port_ctrl_test.sv
// Bench for fts_port_ctrl: a table walk followed by directed tests.
module fts_port_ctrl_test;

    localparam int CLK_P = 10;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          csa_n, csb, csc_n, wr_n, adv_nload, freeze, drv_n;
    logic [NL-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          bus_drive;
    logic [NL-1:0] arr_wstb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    fts_port_ctrl #(.AW(AW), .NL(NL), .LW(LW)) uut (
        .clk(clk), .rst_n(rst_n), .csa_n(csa_n), .csb(csb), .csc_n(csc_n),
        .wr_n(wr_n), .lane_wr_n(lane_wr_n), .adv_nload(adv_nload),
        .freeze(freeze), .drv_n(drv_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .bus_drive(bus_drive), .arr_wstb(arr_wstb)
    );

    always #(CLK_P/2) clk = ~clk;

    // Lane merge from R4: lanes with a low strobe take the new word.
    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w,
                                            logic [DW-1:0] new_w,
                                            logic [NL-1:0] stb_n);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < NL; i++)
            if (!stb_n[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    localparam logic [DW-1:0] D1 = 36'h9A5C31E7F;
    localparam logic [DW-1:0] D2 = 36'h123456789;
    localparam logic [DW-1:0] D3 = 36'hFEDCBA987;
    localparam logic [DW-1:0] D4 = 36'h5A5A5A5A5;
    localparam logic [DW-1:0] DX = 36'hFFFFFFFFF;
    localparam logic [DW-1:0] M  = merge(D2, D3, 4'b1010);

    // cs = {csa_n, csb, csc_n}; 3'b010 selects.
    typedef struct packed {
        logic [2:0]    cs;
        logic          wr_n;
        logic [NL-1:0] stb_n;
        logic          adv;
        logic          frz;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          x_en;
        logic [DW-1:0] x_dat;
        logic [NL-1:0] x_stb;
    } vec_t;

    localparam int NV = 20;
    // Expected columns are the consequence of the previous row's command.
    localparam vec_t TBL [NV] = '{
        '{3'b010, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd15, '0, 1'b0, '0, 4'b0000}, // write 15
        '{3'b100, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd0,  D1, 1'b0, '0, 4'b1111}, // R3 R5 data, R9 advance wraps to 0
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  D2, 1'b0, '0, 4'b1111}, // R9 burst data to word 0
        '{3'b010, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd15, '0, 1'b0, '0, 4'b0000}, // read 15
        '{3'b100, 1'b1, 4'b1111, 1'b1, 1'b0, 4'd0,  '0, 1'b1, D1, 4'b0000}, // R2 read 15, R9 advance
        '{3'b010, 1'b0, 4'b1010, 1'b0, 1'b0, 4'd0,  '0, 1'b1, D2, 4'b0000}, // R9 read of 0; masked write 0
        '{3'b010, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  D3, 1'b0, '0, 4'b0101}, // R4 R7 data cycle; R10 read 0
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b1, 4'd0,  '0, 1'b1, M,  4'b0000}, // R4 R10 merged word; R8 freeze
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  '0, 1'b1, M,  4'b0000}, // R8 held; deselect
        '{3'b010, 1'b0, 4'b0000, 1'b1, 1'b0, 4'd0,  '0, 1'b0, '0, 4'b0000}, // R7 deselected; advance from idle
        '{3'b011, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd5,  '0, 1'b0, '0, 4'b0000}, // R9 still idle; bad select C
        '{3'b110, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  '0, 1'b0, '0, 4'b0000}, // R1 rejected; bad select A
        '{3'b000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  '0, 1'b0, '0, 4'b0000}, // R1 rejected; bad select B
        '{3'b010, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  DX, 1'b0, '0, 4'b0000}, // R1 no strobes; read 0
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  '0, 1'b1, M,  4'b0000}, // R1 word 0 untouched
        '{3'b010, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd7,  '0, 1'b0, '0, 4'b0000}, // write 7
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b1, 4'd0,  DX, 1'b0, '0, 4'b0000}, // R8 R5 frozen data cycle
        '{3'b010, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd7,  D4, 1'b0, '0, 4'b1111}, // R3 commit; R10 read 7
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  '0, 1'b1, D4, 4'b0000}, // R10 new data
        '{3'b100, 1'b1, 4'b1111, 1'b0, 1'b0, 4'd0,  '0, 1'b0, '0, 4'b0000}  // R7 deselected
    };

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic drive(vec_t v);
        {csa_n, csb, csc_n} = v.cs;
        wr_n      = v.wr_n;
        lane_wr_n = v.stb_n;
        adv_nload = v.adv;
        freeze    = v.frz;
        addr      = v.a;
        wdata     = v.d;
    endtask

    task automatic cmd(logic [2:0] cs, logic w, logic [AW-1:0] a);
        vec_t v = '0;
        v.cs = cs; v.wr_n = w; v.stb_n = 4'b0000; v.a = a;
        drive(v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog got timeout exp completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drv_n = 1'b0;
        cmd(3'b100, 1'b1, '0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R11", {35'd0, bus_drive}, '0);
        chk("R11", {32'd0, arr_wstb}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #1;
            chk("R2_R7", {35'd0, bus_drive}, {35'd0, TBL[i].x_en});
            chk("R5", {32'd0, arr_wstb}, {32'd0, TBL[i].x_stb});
            if (TBL[i].x_en) chk("R2", rdata, TBL[i].x_dat);
        end

        // R6: asynchronous drive request during a read of word 15.
        @(negedge clk);
        cmd(3'b010, 1'b1, 4'd15);
        @(negedge clk);
        cmd(3'b100, 1'b1, '0);
        #1;
        chk("R2", rdata, D1);
        chk("R6", {35'd0, bus_drive}, 36'd1);
        drv_n = 1'b1;
        #1;
        chk("R6", {35'd0, bus_drive}, '0);
        drv_n = 1'b0;
        #1;
        chk("R6", {35'd0, bus_drive}, 36'd1);

        // R11: reset taken at the edge that loads a write.
        @(negedge clk);
        cmd(3'b010, 1'b1, 4'd15);
        @(negedge clk);
        cmd(3'b010, 1'b0, 4'd2);
        rst_n = 1'b0;
        #1;
        chk("R11", {35'd0, bus_drive}, 36'd1);
        @(negedge clk);
        cmd(3'b100, 1'b1, '0);
        rst_n = 1'b1;
        #1;
        chk("R11", {35'd0, bus_drive}, '0);
        chk("R11", {32'd0, arr_wstb}, '0);

        @(negedge clk);
        finish_run();
    end

endmodule